// File: doc/BRIEF.md
# Expansion Configuration Responder

This block is the slave side of a nibble-wide expansion configuration handshake for a single 8 MB memory board. While the board is still in the chain, the host reads identity nibbles through a byte-wide register port that covers a 64 KB configuration window. The host then either assigns a base address with two writes or tells the board to stand down. After either of these the board leaves the chain and the window is no longer decoded.

Read data is registered and appears one clock after the read strobe. Each byte carries an identity nibble in bits [7:4]. All offsets invert the byte except four, which return it true. The configured base leaves the block as a 24-bit address whose low 16 bits are always zero. Two flags go with it: one says that a base was assigned and one says that the chain is done.

Top module: `acfg_responder`

## Requirements
- R1: One clock after `rd_en` is sampled high with the window decoded, `rd_data` holds, in bits [7:4], the identity nibble at index `reg_off/2` for an even offset, with bits [3:0] zero. The nibbles for indices 0 to 19 are E,0,6,9,8,0,0,0,0,7,D,B,0,0,0,0,0,4,2,0.
- R2: An odd offset, or an even offset whose index is 20 or more, gives a byte of 0x00 before the inversion rule.
- R3: The byte is bit-inverted for every offset except decimal 0, 2, 40 and 42, which return it unchanged. For example, offset 4 reads 0x9F, offset 1 reads 0xFF and offset 40 reads 0x00.
- R4: In any cycle that follows one with no decoded read, `rd_data` is 0x00.
- R5: A decoded write at offset 0x4A sets base bits [19:16] from `wr_data[7:4]` and clears all other base bits. The new base is visible one clock later.
- R6: A decoded write at offset 0x48 sets base bits [23:20] from `wr_data[7:4]`, keeps bits [19:16], and raises `configured`.
- R7: A decoded write at offset 0x4C raises `chain_done` without raising `configured` and without changing the base.
- R8: A write at 0x48 or 0x4C advances the board index. When the index reaches `NUM_BOARDS` (default 1), `chain_done` rises and stays high. From then on reads return 0x00 and every write is ignored.
- R9: A write to any offset other than 0x48, 0x4A and 0x4C changes neither the base nor either flag.
- R10: While `rst` is high at a clock edge, the base, `configured`, `chain_done` and `rd_data` clear to zero.
- R11: `base_addr[15:0]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_off | input | 16 | Byte offset inside the configuration window |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| base_addr | output | 24 | Assigned base address |
| configured | output | 1 | A base address has been committed |
| chain_done | output | 1 | The board has left the configuration chain |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle, and that `reg_off` and `wr_data` are stable around the sampling edge. The bench drives all inputs on the falling edge and raises only one strobe at a time. The stimulus sweeps every offset from 0 to 50 and a few far offsets, tries stray writes, writes 0x4A twice, and runs both the commit path and the stand-down path, each from a fresh reset. Once `chain_done` is high, both strobes are still issued to show that the window is closed.

// File: rtl/acfg_pkg.sv
package acfg_pkg;
  localparam int OFF_W    = 16;
  localparam int ID_DEPTH = 20;
  localparam int BASE_HI_W = 8;

  // identity nibble table, index = offset / 2
  function automatic logic [3:0] id_nibble(input logic [4:0] idx);
    logic [3:0] n;
    case (idx)
      5'd0:  n = 4'hE;
      5'd2:  n = 4'h6;
      5'd3:  n = 4'h9;
      5'd4:  n = 4'h8;
      5'd9:  n = 4'h7;
      5'd10: n = 4'hD;
      5'd11: n = 4'hB;
      5'd17: n = 4'h4;
      5'd18: n = 4'h2;
      default: n = 4'h0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/acfg_rom.sv
module acfg_rom
  import acfg_pkg::*;
#(
  parameter int OW = OFF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          decode_en,
  input  logic [OW-1:0] off,
  output logic [7:0]    rd_data
);
  localparam int IDX_W = OW - 1;

  logic [IDX_W-1:0] idx;
  logic             in_tbl;
  logic [3:0]       nib;
  logic [7:0]       raw;
  logic             pass_true;
  logic [7:0]       next_byte;

  always_comb begin
    idx       = off[OW-1:1];
    in_tbl    = !off[0] && (idx < IDX_W'(ID_DEPTH));
    nib       = in_tbl ? id_nibble(idx[4:0]) : 4'h0;
    raw       = {nib, 4'h0};
    pass_true = (off == OW'(0)) || (off == OW'(2)) ||
                (off == OW'(40)) || (off == OW'(42));
    next_byte = pass_true ? raw : ~raw;
  end

  always_ff @(posedge clk) begin
    if (rst)                        rd_data <= 8'h00;
    else if (rd_en && decode_en)    rd_data <= next_byte;
    else                            rd_data <= 8'h00;
  end

  // R2
  odd_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && decode_en && off[0] && off != OW'(0)) |=> (rd_data == 8'hFF));
endmodule

// File: rtl/acfg_ctrl.sv
module acfg_ctrl
  import acfg_pkg::*;
#(
  parameter int          OW         = OFF_W,
  parameter int          NUM_BOARDS = 1,
  parameter logic [15:0] HI_OFF     = 16'h0048,
  parameter logic [15:0] LO_OFF     = 16'h004A,
  parameter logic [15:0] SHUT_OFF   = 16'h004C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [OW-1:0]        off,
  input  logic [7:0]           wr_data,
  output logic [BASE_HI_W-1:0] base_hi,
  output logic                 configured,
  output logic                 chain_done
);
  localparam int BI_W = $clog2(NUM_BOARDS + 1);

  logic [BI_W-1:0] board_idx;
  logic            wr_ok, hit_hi, hit_lo, hit_shut, advance;

  always_comb begin
    wr_ok    = wr_en && !chain_done;
    hit_hi   = wr_ok && (off == OW'(HI_OFF));
    hit_lo   = wr_ok && (off == OW'(LO_OFF));
    hit_shut = wr_ok && (off == OW'(SHUT_OFF));
    advance  = hit_hi || hit_shut;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi    <= '0;
      configured <= 1'b0;
      chain_done <= 1'b0;
      board_idx  <= '0;
    end else begin
      if (hit_lo) base_hi <= {4'h0, wr_data[7:4]};
      if (hit_hi) begin
        base_hi[7:4] <= wr_data[7:4];
        configured   <= 1'b1;
      end
      if (advance) begin
        board_idx <= board_idx + 1'b1;
        if (board_idx + 1'b1 == BI_W'(NUM_BOARDS)) chain_done <= 1'b1;
      end
    end
  end

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    chain_done |=> chain_done);

  // R6
  cfg_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(configured) |-> $past(wr_en && off == OW'(HI_OFF)));

  // R9
  base_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(base_hi));

  // R8
  closed_write_chk: assert property (@(posedge clk) disable iff (rst)
    chain_done |=> ($stable(base_hi) && $stable(configured)));
endmodule

// File: rtl/acfg_responder.sv
module acfg_responder
  import acfg_pkg::*;
#(
  parameter int NUM_BOARDS = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] reg_off,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic [23:0]      base_addr,
  output logic             configured,
  output logic             chain_done
);
  localparam int LOW_ZERO_W = 24 - BASE_HI_W;

  logic [BASE_HI_W-1:0] base_hi;

  acfg_ctrl #(.OW(OFF_W), .NUM_BOARDS(NUM_BOARDS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .off        (reg_off),
    .wr_data    (wr_data),
    .base_hi    (base_hi),
    .configured (configured),
    .chain_done (chain_done)
  );

  acfg_rom #(.OW(OFF_W)) u_rom (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .decode_en (!chain_done),
    .off       (reg_off),
    .rd_data   (rd_data)
  );

  assign base_addr = {base_hi, {LOW_ZERO_W{1'b0}}};

  // R8
  closed_read_chk: assert property (@(posedge clk) disable iff (rst)
    chain_done |=> (rd_data == 8'h00));

  // R7
  shut_nocfg_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !chain_done && reg_off == 16'h004C && !configured) |=> !configured);
endmodule

// File: tb/acfg_responder_tb.sv
module acfg_responder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reg_off = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [23:0] base_addr;
  logic        configured, chain_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit armed = 0;
  bit finished = 0;

  int id_tab [20] = '{14, 0, 6, 9, 8, 0, 0, 0, 0, 7, 13, 11, 0, 0, 0, 0, 0, 4, 2, 0};

  // reference state
  int m_rd = 0;
  int m_base = 0;
  bit m_cfg = 0;
  bit m_done = 0;
  int m_boards = 0;

  always #5 clk = ~clk;

  acfg_responder u_dut (
    .clk(clk), .rst(rst), .reg_off(reg_off), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .base_addr(base_addr),
    .configured(configured), .chain_done(chain_done)
  );

  function automatic int ref_read(int off);
    int v;
    v = 0;
    if ((off % 2) == 0 && (off / 2) < 20) v = id_tab[off / 2] * 16;
    if (!(off == 0 || off == 2 || off == 40 || off == 42)) v = 255 - v;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rd = 0; m_base = 0; m_cfg = 0; m_done = 0; m_boards = 0;
    end else begin
      m_rd = (rd_en && !m_done) ? ref_read(int'(reg_off)) : 0;
      if (wr_en && !m_done) begin
        if (reg_off == 16'h4A) m_base = int'(wr_data[7:4]) * 65536;
        else if (reg_off == 16'h48) begin
          m_base = (m_base % 1048576) + int'(wr_data[7:4]) * 1048576;
          m_cfg = 1;
          m_boards = m_boards + 1;
          if (m_boards == 1) m_done = 1;
        end else if (reg_off == 16'h4C) begin
          m_boards = m_boards + 1;
          if (m_boards == 1) m_done = 1;
        end
      end
    end
    armed = 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (armed && !finished) begin
      chk(rst ? "R10 rd_data" : "R1/R2/R3/R4/R8 rd_data", int'(rd_data), m_rd);
      chk(rst ? "R10 base" : "R5/R6/R9 base", int'(base_addr), m_base);
      chk("R11 base low", int'(base_addr[15:0]), 0);
      chk(rst ? "R10 configured" : "R6/R7 configured", int'(configured), int'(m_cfg));
      chk(rst ? "R10 chain_done" : "R7/R8 chain_done", int'(chain_done), int'(m_done));
    end
  end

  task automatic idle();
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  task automatic do_rd(int off);
    @(negedge clk);
    wr_en = 0; rd_en = 1; reg_off = 16'(off);
  endtask

  task automatic do_wr(int off, int d);
    @(negedge clk);
    rd_en = 0; wr_en = 1; reg_off = 16'(off); wr_data = 8'(d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rd_en = 0; wr_en = 0; rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    do_reset();
    // R1 R2 R3: sweep the table region and beyond
    for (int o = 0; o <= 50; o++) do_rd(o);
    do_rd(16'h0100); do_rd(16'hFFFE); do_rd(16'hFFFF);
    // R4: idle gaps
    idle(); idle();
    do_rd(4); idle(); do_rd(0);
    // R9: stray writes
    do_wr(16'h0000, 16'hF0); do_wr(16'h0049, 16'hF0); do_wr(16'h004E, 16'hF0);
    // R5: low nibble twice, second replaces first
    do_wr(16'h4A, 16'h30); idle();
    do_wr(16'h4A, 16'h5F); idle();
    // R6 R8: commit
    do_wr(16'h48, 16'hA0); idle();
    // R8: window closed
    do_rd(0); do_rd(4); do_wr(16'h4A, 16'hF0); do_wr(16'h48, 16'h10); do_wr(16'h4C, 16'h00);
    idle(); idle();
    // R10: reset clears everything
    do_reset();
    idle();
    // R7: stand down path
    do_wr(16'h4A, 16'h70); idle();
    do_wr(16'h4C, 16'h00); idle();
    do_rd(0); do_wr(16'h48, 16'hC0); idle(); idle();
    // R6 without prior low write
    do_reset();
    do_wr(16'h48, 16'h90); idle(); idle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule